// File: doc/BRIEF.md
# Capacitive ADC Front-End Sequencer

This block sequences the front end of a sample-and-hold conversion for capacitive voltage-divider touch sensing. Any one of three start sources begins a sequence: a software go strobe, an external event trigger, or a restart request from post-conversion processing. Only a start that arrives while the block is idle has an effect. The block then runs an optional precharge phase followed by an optional acquisition phase. Both phases are timed in ADC clock enables from counts that are captured at the start. When the timing ends, it hands off to the converter with a single-cycle strobe.

During precharge, the hold capacitor is cut off from the outer path and tied to one rail. The selected pin is forced to drive the opposite logic level, so charge sharing starts from a known difference. During acquisition the pin drivers are released and the channel is joined to the hold capacitor. Two guard-ring drive outputs follow the phases so that guard traces track the sensing electrode. In double-sample mode, a second precharge/acquisition pass runs after the converter reports completion. In that pass the guard polarity can optionally be inverted.

All pins are plain control and status levels or strobes. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `cvd_frontend_seq`

## Requirements
- R1: When the block is idle (busy low), a high level on any of sw_go, ext_trig or restart_req at a clock edge starts a sequence, and busy is high from the next cycle.
- R2: A start request on any source while busy is high is ignored: no additional phase, strobe or done pulse is produced, and busy returns low after the running sequence ends.
- R3: A nonzero captured precharge count N gives a precharge phase of exactly N clock cycles in which adc_ce is high. A zero count skips precharge.
- R4: Throughout precharge, pin_ovr_en and hold_to_rail are high and chan_connect is low. hold_rail_hi equals the captured precharge-polarity bit and pin_ovr_lvl equals its inverse. Outside precharge all four of these outputs are low.
- R5: Acquisition follows precharge, or begins at sequence start when precharge is skipped. During acquisition chan_connect is high and pin_ovr_en is low, for exactly M adc_ce-high cycles when the captured acquisition count M is nonzero.
- R6: An acquisition count of zero with a nonzero precharge count gives an acquisition of 256 adc_ce-high cycles.
- R7: Zero precharge and zero acquisition counts skip hardware timing entirely: conv_start is high in the cycle right after the start edge.
- R8: conv_start is a single-cycle pulse that immediately follows the end of acquisition (or of the start, per R7).
- R9: At the start of the first sample, guard_a and guard_b both take the captured guard-polarity bit. On entry to acquisition, guard_a inverts and guard_b holds.
- R10: With double-sample enabled, the first sar_done starts a second pass. At its start both guard outputs become the inverse of the guard-polarity bit if invert-enable is set, or equal to it otherwise. guard_a inverts again on entry to the second acquisition.
- R11: sar_done after the final conv_start ends the sequence: seq_done is high for exactly one cycle, in which busy is already low.
- R12: Counts and polarity/mode bits are captured at the start edge. Changes to the cfg_* inputs during a sequence do not alter it.
- R13: Phase counters advance only on cycles with adc_ce high. Cycles with adc_ce low extend a phase without consuming its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_ce | input | 1 | ADC clock enable; one phase count per high cycle |
| sw_go | input | 1 | Software go request |
| ext_trig | input | 1 | External event trigger |
| restart_req | input | 1 | Restart request from post-conversion logic |
| cfg_pre_cnt | input | CNT_W (8) | Precharge length in enabled cycles; 0 skips |
| cfg_acq_cnt | input | CNT_W (8) | Acquisition length in enabled cycles; 0 means 256 or none (R6, R7) |
| cfg_pre_pol | input | 1 | 1: hold capacitor to supply, pin driven low; 0: the reverse |
| cfg_guard_pol | input | 1 | Initial guard output level |
| cfg_inv_en | input | 1 | Invert guard outputs on the second pass |
| cfg_dbl | input | 1 | Double-sample mode |
| sar_done | input | 1 | Converter finished the current sample |
| busy | output | 1 | A sequence is running |
| hold_to_rail | output | 1 | Hold capacitor tied to a rail (precharge) |
| hold_rail_hi | output | 1 | Rail select for the hold capacitor: 1 supply |
| pin_ovr_en | output | 1 | Pin output override active |
| pin_ovr_lvl | output | 1 | Level driven by the pin override |
| chan_connect | output | 1 | Channel connected to hold capacitor (acquisition) |
| conv_start | output | 1 | Single-cycle strobe: conversion may begin |
| guard_a | output | 1 | Guard drive A |
| guard_b | output | 1 | Guard drive B |
| seq_done | output | 1 | Single-cycle end-of-sequence pulse |

## Verification
A corrupted state register or phase counter shows up at once as a precharge or acquisition window of the wrong length. The same fault can also appear as a missing or doubled conv_start pulse, and these are visible within one phase of the fault. A wrong guard register shows up at the next phase boundary, where guard_a must invert and guard_b must hold. A second-pass flag that is stuck or lost shows up as an extra or missing pass after the first sar_done, and also as a seq_done pulse that arrives one pass early or late. The scoreboard compares every phase window (length counted in enabled cycles, guard levels, override and rail levels) against a model built from the captured configuration. Any spurious phase from an ignored start is reported as an unexpected window.

// File: rtl/cvd_seq_pkg.sv
package cvd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_ACQ  = 3'd2,
    ST_CONV = 3'd3,
    ST_WAIT = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic pre_pol;
    logic guard_pol;
    logic inv_en;
    logic dbl;
  } seq_flags_t;

endpackage

// File: rtl/cvd_start_capture.sv
module cvd_start_capture
  import cvd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             sw_go,
  input  logic             ext_trig,
  input  logic             restart_req,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_acq,
  input  seq_flags_t       cfg_flags,
  output logic             launch,
  output logic [CNT_W-1:0] pre_eff,
  output logic [CNT_W-1:0] acq_eff,
  output seq_flags_t       flags_eff
);

  localparam int NSRC = 3;

  logic [NSRC-1:0]  src_vec;
  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] acq_q;
  seq_flags_t       flags_q;

  assign src_vec = {restart_req, ext_trig, sw_go};
  assign launch  = idle && (|src_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      acq_q   <= '0;
      flags_q <= '0;
    end else if (launch) begin
      pre_q   <= cfg_pre;
      acq_q   <= cfg_acq;
      flags_q <= cfg_flags;
    end
  end

  // On the launch edge the live configuration is used; afterwards the copy.
  assign pre_eff   = launch ? cfg_pre   : pre_q;
  assign acq_eff   = launch ? cfg_acq   : acq_q;
  assign flags_eff = launch ? cfg_flags : flags_q;

  // R12
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (pre_q == $past(pre_q) && acq_q == $past(acq_q)));

endmodule

// File: rtl/cvd_phase_timer.sv
module cvd_phase_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  input  logic          ce,
  output logic          last
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (run && ce && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = run && ce && (cnt_q == TW'(1));

  // R3
  timer_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));

  // R13
  timer_ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ce && !load) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/cvd_guard_drive.sv
module cvd_guard_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic first_evt,
  input  logic second_evt,
  input  logic acq_evt,
  input  logic gpol,
  input  logic inv_en,
  output logic ga,
  output logic gb
);

  logic base;

  always_comb begin
    base = gpol;
    if (second_evt && inv_en) base = ~gpol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ga <= 1'b0;
      gb <= 1'b0;
    end else if (first_evt || second_evt) begin
      ga <= base ^ acq_evt;
      gb <= base;
    end else if (acq_evt) begin
      ga <= ~ga;
    end
  end

  // R9
  guard_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_evt && !first_evt && !second_evt) |=> $stable(gb));

  // R9
  guard_a_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_evt && !first_evt && !second_evt) |=> (ga != $past(ga)));

endmodule

// File: rtl/cvd_frontend_seq.sv
module cvd_frontend_seq
  import cvd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adc_ce,
  input  logic             sw_go,
  input  logic             ext_trig,
  input  logic             restart_req,
  input  logic [CNT_W-1:0] cfg_pre_cnt,
  input  logic [CNT_W-1:0] cfg_acq_cnt,
  input  logic             cfg_pre_pol,
  input  logic             cfg_guard_pol,
  input  logic             cfg_inv_en,
  input  logic             cfg_dbl,
  input  logic             sar_done,
  output logic             busy,
  output logic             hold_to_rail,
  output logic             hold_rail_hi,
  output logic             pin_ovr_en,
  output logic             pin_ovr_lvl,
  output logic             chan_connect,
  output logic             conv_start,
  output logic             guard_a,
  output logic             guard_b,
  output logic             seq_done
);

  localparam int            TW      = CNT_W + 1;
  localparam logic [TW-1:0] ACQ_MAX = TW'(1 << CNT_W);

  seq_state_t       state_q, state_d;
  logic             second_q, second_d;
  logic             done_q, done_d;
  logic             launch;
  logic [CNT_W-1:0] pre_eff, acq_eff;
  seq_flags_t       cfg_flags, flags_eff;
  logic             ld;
  logic [TW-1:0]    ld_val;
  logic             t_run, t_last;
  logic             acq_evt, second_evt, sample_go;

  assign cfg_flags = '{pre_pol: cfg_pre_pol, guard_pol: cfg_guard_pol,
                       inv_en: cfg_inv_en, dbl: cfg_dbl};

  cvd_start_capture #(.CNT_W(CNT_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle        (state_q == ST_IDLE),
    .sw_go       (sw_go),
    .ext_trig    (ext_trig),
    .restart_req (restart_req),
    .cfg_pre     (cfg_pre_cnt),
    .cfg_acq     (cfg_acq_cnt),
    .cfg_flags   (cfg_flags),
    .launch      (launch),
    .pre_eff     (pre_eff),
    .acq_eff     (acq_eff),
    .flags_eff   (flags_eff)
  );

  assign t_run = (state_q == ST_PRE) || (state_q == ST_ACQ);

  cvd_phase_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .run      (t_run),
    .ce       (adc_ce),
    .last     (t_last)
  );

  always_comb begin
    state_d    = state_q;
    second_d   = second_q;
    done_d     = 1'b0;
    ld         = 1'b0;
    ld_val     = '0;
    acq_evt    = 1'b0;
    second_evt = 1'b0;
    sample_go  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          second_d  = 1'b0;
          sample_go = 1'b1;
        end
      end
      ST_PRE: begin
        if (t_last) begin
          state_d = ST_ACQ;
          ld      = 1'b1;
          ld_val  = (acq_eff == '0) ? ACQ_MAX : TW'(acq_eff);
          acq_evt = 1'b1;
        end
      end
      ST_ACQ: begin
        if (t_last) state_d = ST_CONV;
      end
      ST_CONV: state_d = ST_WAIT;
      ST_WAIT: begin
        if (sar_done) begin
          if (flags_eff.dbl && !second_q) begin
            second_d   = 1'b1;
            second_evt = 1'b1;
            sample_go  = 1'b1;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (sample_go) begin
      if (pre_eff != '0) begin
        state_d = ST_PRE;
        ld      = 1'b1;
        ld_val  = TW'(pre_eff);
      end else if (acq_eff != '0) begin
        state_d = ST_ACQ;
        ld      = 1'b1;
        ld_val  = TW'(acq_eff);
        acq_evt = 1'b1;
      end else begin
        state_d = ST_CONV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
      done_q   <= done_d;
    end
  end

  cvd_guard_drive u_grd (
    .clk        (clk),
    .rst_n      (rst_n),
    .first_evt  (launch),
    .second_evt (second_evt),
    .acq_evt    (acq_evt),
    .gpol       (flags_eff.guard_pol),
    .inv_en     (flags_eff.inv_en),
    .ga         (guard_a),
    .gb         (guard_b)
  );

  assign busy         = (state_q != ST_IDLE);
  assign hold_to_rail = (state_q == ST_PRE);
  assign hold_rail_hi = (state_q == ST_PRE) &&  flags_eff.pre_pol;
  assign pin_ovr_en   = (state_q == ST_PRE);
  assign pin_ovr_lvl  = (state_q == ST_PRE) && !flags_eff.pre_pol;
  assign chan_connect = (state_q == ST_ACQ);
  assign conv_start   = (state_q == ST_CONV);
  assign seq_done     = done_q;

  // R8
  conv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R5
  ovr_vs_connect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ovr_en |-> !chan_connect);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !busy);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && (sw_go || ext_trig || restart_req)) |=> busy);

  // R4
  rail_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ovr_en |-> (hold_rail_hi != pin_ovr_lvl));

endmodule

// File: tb/tb_cvd_frontend_seq.sv
`timescale 1ns/1ps
module tb_cvd_frontend_seq;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             adc_ce = 1'b1;
  logic             sw_go = 1'b0, ext_trig = 1'b0, restart_req = 1'b0;
  logic [CNT_W-1:0] cfg_pre_cnt = '0, cfg_acq_cnt = '0;
  logic             cfg_pre_pol = 1'b0, cfg_guard_pol = 1'b0;
  logic             cfg_inv_en = 1'b0, cfg_dbl = 1'b0;
  logic             sar_done = 1'b0;
  logic             busy, hold_to_rail, hold_rail_hi, pin_ovr_en, pin_ovr_lvl;
  logic             chan_connect, conv_start, guard_a, guard_b, seq_done;

  cvd_frontend_seq #(.CNT_W(CNT_W)) dut (.*);

  always #2 clk = ~clk;

  int  total = 0;
  int  bad = 0;
  bit  ce_alt = 1'b0;

  typedef struct {
    int    code;
    int    len;
    bit    ga, gb, hsw, hhi, lvl;
    string tag;
  } item_t;

  item_t exp_q[$];

  task automatic check(bit ok, string tag, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic push(int code, int len, bit ga, bit gb, bit hsw, bit hhi,
                      bit lvl, string tag);
    item_t it;
    it.code = code; it.len = len; it.ga = ga; it.gb = gb;
    it.hsw = hsw; it.hhi = hhi; it.lvl = lvl; it.tag = tag;
    exp_q.push_back(it);
  endtask

  function automatic string fmt(item_t it);
    return $sformatf("code=%0d len=%0d ga=%0b gb=%0b hsw=%0b hhi=%0b lvl=%0b",
                     it.code, it.len, it.ga, it.gb, it.hsw, it.hhi, it.lvl);
  endfunction

  task automatic compare(item_t act);
    item_t ex;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2", $sformatf("unexpected window actual %s expected none",
                                  fmt(act)));
      return;
    end
    ex = exp_q.pop_front();
    check(act.code == ex.code && act.len == ex.len && act.ga == ex.ga &&
          act.gb == ex.gb && act.hsw == ex.hsw && act.hhi == ex.hhi &&
          act.lvl == ex.lvl, ex.tag,
          $sformatf("actual %s expected %s", fmt(act), fmt(ex)));
  endtask

  // adc_ce changes just after each rising edge, stable at the sampling point
  initial forever begin
    @(posedge clk);
    #1 adc_ce = ce_alt ? ~adc_ce : 1'b1;
  end

  // converter model
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      repeat (3) @(negedge clk);
      sar_done = 1'b1;
      @(negedge clk);
      sar_done = 1'b0;
    end
  end

  // monitor: splits outputs into phase windows and compares them
  initial begin
    int    cur;
    int    code;
    item_t it;
    cur = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        code = pin_ovr_en ? 1 : chan_connect ? 2 : conv_start ? 3 : 0;
        if (code != cur) begin
          if (cur != 0) compare(it);
          if (code != 0) begin
            it.code = code; it.len = 0; it.ga = guard_a; it.gb = guard_b;
            it.hsw = hold_to_rail; it.hhi = hold_rail_hi; it.lvl = pin_ovr_lvl;
            it.tag = "";
          end
          cur = code;
        end
        if (code == 3) it.len++;
        else if (code != 0 && adc_ce) it.len++;
        if (seq_done) begin
          item_t d;
          d.code = 4; d.len = 0; d.ga = guard_a; d.gb = guard_b;
          d.hsw = hold_to_rail; d.hhi = hold_rail_hi; d.lvl = pin_ovr_lvl;
          d.tag = "";
          compare(d);
        end
      end
    end
  end

  // driver: predicts the windows, then fires one start
  task automatic run_seq(int src, int pre, int acq, bit pol, bit gpol,
                         bit inv, bit dbl, bit poke);
    bit ga, gb;
    int acq_len;
    ga = gpol; gb = gpol;
    for (int s = 0; s <= (dbl ? 1 : 0); s++) begin
      if (s == 1) begin
        ga = inv ? ~gpol : gpol;
        gb = ga;
      end
      if (pre > 0) push(1, pre, ga, gb, 1'b1, pol, ~pol, s == 1 ? "R10" : "R4");
      acq_len = (acq != 0) ? acq : (pre != 0 ? 256 : 0);
      if (acq_len > 0) begin
        ga = ~ga;
        push(2, acq_len, ga, gb, 1'b0, 1'b0, 1'b0, s == 1 ? "R10" : "R9");
      end
      push(3, 1, ga, gb, 1'b0, 1'b0, 1'b0, "R8");
    end
    push(4, 0, ga, gb, 1'b0, 1'b0, 1'b0, "R11");

    @(negedge clk);
    cfg_pre_cnt = CNT_W'(pre); cfg_acq_cnt = CNT_W'(acq);
    cfg_pre_pol = pol; cfg_guard_pol = gpol; cfg_inv_en = inv; cfg_dbl = dbl;
    case (src)
      0: sw_go = 1'b1;
      1: ext_trig = 1'b1;
      default: restart_req = 1'b1;
    endcase
    @(negedge clk);
    sw_go = 1'b0; ext_trig = 1'b0; restart_req = 1'b0;
    check(busy === 1'b1, "R1", $sformatf("busy after start src=%0d actual %0b expected 1",
                                          src, busy));
    if (pre == 0 && acq == 0)
      check(conv_start === 1'b1, "R7",
            $sformatf("conv_start after start actual %0b expected 1", conv_start));
    if (poke) begin
      // R12: scramble configuration; R2: retrigger while running
      cfg_pre_cnt = 8'd1; cfg_acq_cnt = 8'd1; cfg_pre_pol = ~pol;
      cfg_guard_pol = ~gpol; cfg_dbl = ~dbl; cfg_inv_en = ~inv;
      @(negedge clk);
      ext_trig = 1'b1; sw_go = 1'b1;
      @(negedge clk);
      ext_trig = 1'b0; sw_go = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    check(busy === 1'b0, "R2", $sformatf("busy long after done actual %0b expected 0", busy));
    check(exp_q.size() == 0, "R11",
          $sformatf("windows still expected actual %0d expected 0", exp_q.size()));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, hold_to_rail, hold_rail_hi, pin_ovr_en, pin_ovr_lvl, chan_connect,
           conv_start, guard_a, guard_b, seq_done} === 10'b0, "R11",
          "reset outputs not all zero");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_seq(0, 3, 4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // R3 R4 R5 R9
    run_seq(1, 0, 5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // R1 R3 skip, R5
    run_seq(2, 2, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);   // R1 R6
    run_seq(0, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R7
    run_seq(1, 2, 3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);   // R10 inverted
    run_seq(2, 1, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);   // R10 non-inverted
    run_seq(0, 0, 3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);   // R10 without precharge
    ce_alt = 1'b1;
    run_seq(0, 5, 3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R13
    ce_alt = 1'b0;
    run_seq(1, 6, 4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);   // R2 R12

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule